// File: doc/BRIEF.md
# Storage Command Register Block

This block sits on the device side of a simple register-driven storage command path. A host bus stores a sector count, a 28-bit block address and a device selector into a small register file. It then starts an operation by writing an opcode to the command address. Software sees the outcome through a fixed-layout status byte and a level interrupt.

The block models execution only as a timed busy period. A supported opcode holds the busy flag for `EXEC_CYCLES` clock cycles and then completes cleanly. An unknown opcode is rejected at once with the error flag. While busy, the block drops every host write, so the parameters of the running command cannot change under it. Media access, the data port and DMA are not part of this block.

Register addresses: 0 sector count, 1 address bits 7:0, 2 address bits 15:8, 3 address bits 23:16, 4 device selector, 5 command (write) and status (read). Addresses 6 and 7 read as zero.

Top module: `disk_taskfile`

## Requirements
- R1: After reset, status reads 0x40 (idle, ready), addresses 0 to 3 read 0x00, address 4 reads 0xE0, and `irq` is low.
- R2: While not busy, a write to address 0, 1, 2 or 3 stores the byte, and a read of that address returns it.
- R3: Only the low four bits of a write to address 4 are kept, as address bits 27:24. Address 4 always reads with its upper nibble equal to binary 1110, so it reads 0xE0 ORed with the stored nibble.
- R4: A write to address 5 of a supported opcode (0x20, 0x30, 0x40, 0xE7) while not busy makes status read 0x80 from the next cycle on, with busy at bit 7, ready at bit 6 low and error at bit 0 cleared. Status reads 0x80 for exactly `EXEC_CYCLES` cycles and then 0x40.
- R5: A write to address 5 of any other opcode while not busy never sets busy. From the next cycle status reads 0x41 (ready and error) and `irq` is high.
- R6: While busy, writes to any address are ignored. Stored parameters keep their values, and a command write neither restarts nor lengthens the busy period.
- R7: `irq` rises on every completion, good or failed. It stays high until a read of address 5 with `host_rd` high, and it is cleared when a supported command starts.
- R8: Writes to addresses other than 5 never start execution: busy stays low.
- R9: Status bits 5 to 1 always read 0, including the data-request bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Write strobe, sampled on the clock edge |
| host_rd | input | 1 | Read strobe; a read of address 5 clears `irq` |
| host_addr | input | 3 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Combinational read data for `host_addr` |
| irq | output | 1 | Level completion interrupt |

## Verification
On every cycle, the bound checker enforces several properties: busy excludes ready, and a busy run never exceeds `EXEC_CYCLES`. The parameter registers stay frozen while busy. Idle cycles without a command write cannot raise busy. The interrupt only drops on a status read or a new start, and a supported or unknown opcode leads to the right flags on the next cycle. The exact read-back values, the forced 1110 nibble of the device register and the exact cycle on which status returns to 0x40 can only be shown by the bench scenarios. The same holds for the rule that a command written during busy does not shift that cycle.

// File: rtl/tf_pkg.sv
package tf_pkg;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_COUNT = 3'd0;
    localparam logic [ADDR_W-1:0] A_LBA0  = 3'd1;
    localparam logic [ADDR_W-1:0] A_LBA1  = 3'd2;
    localparam logic [ADDR_W-1:0] A_LBA2  = 3'd3;
    localparam logic [ADDR_W-1:0] A_DEV   = 3'd4;
    localparam logic [ADDR_W-1:0] A_CMD   = 3'd5;

    // status bit positions are fixed by the host software contract
    localparam int ST_BUSY = 7;
    localparam int ST_RDY  = 6;
    localparam int ST_DRQ  = 3;
    localparam int ST_ERR  = 0;

    localparam logic [3:0] DEV_MODE_NIB = 4'b1110;

    typedef struct packed {
        logic [DATA_W-1:0] count;
        logic [DATA_W-1:0] lba0;
        logic [DATA_W-1:0] lba1;
        logic [DATA_W-1:0] lba2;
        logic [3:0]        lba_top;
    } tf_params_t;

    function automatic logic op_known(input logic [DATA_W-1:0] op);
        return (op == 8'h20) || (op == 8'h30) || (op == 8'h40) || (op == 8'hE7);
    endfunction

endpackage

// File: rtl/tf_param_regs.sv
module tf_param_regs
    import tf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output tf_params_t        prm
);

    tf_params_t prm_d, prm_q;

    always_comb begin
        prm_d = prm_q;
        if (wr_ok) begin
            case (addr)
                A_COUNT: prm_d.count   = wdata;
                A_LBA0:  prm_d.lba0    = wdata;
                A_LBA1:  prm_d.lba1    = wdata;
                A_LBA2:  prm_d.lba2    = wdata;
                A_DEV:   prm_d.lba_top = wdata[3:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prm_q <= '0;
        else        prm_q <= prm_d;
    end

    assign prm = prm_q;

endmodule

// File: rtl/tf_exec.sv
module tf_exec
    import tf_pkg::*;
#(
    parameter int EXEC_CYCLES = 6
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [DATA_W-1:0] op,
    input  logic              status_rd,
    output logic              busy,
    output logic              drdy,
    output logic              err,
    output logic              irq
);

    localparam int CNT_W = $clog2(EXEC_CYCLES + 1);

    typedef struct packed {
        logic             busy;
        logic             drdy;
        logic             err;
        logic             irq;
        logic [CNT_W-1:0] cnt;
    } exec_t;

    exec_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (status_rd) st_d.irq = 1'b0;
        if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
                st_d.drdy = 1'b1;
                st_d.irq  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (go) begin
            if (op_known(op)) begin
                st_d.busy = 1'b1;
                st_d.drdy = 1'b0;
                st_d.err  = 1'b0;
                st_d.irq  = 1'b0;
                st_d.cnt  = CNT_W'(EXEC_CYCLES - 1);
            end else begin
                st_d.drdy = 1'b1;
                st_d.err  = 1'b1;
                st_d.irq  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.drdy <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
    assign drdy = st_q.drdy;
    assign err  = st_q.err;
    assign irq  = st_q.irq;

endmodule

// File: rtl/disk_taskfile.sv
module disk_taskfile
    import tf_pkg::*;
#(
    parameter int EXEC_CYCLES = 6
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              irq
);

    logic       busy, drdy, err;
    logic       wr_ok, go, status_rd;
    tf_params_t prm;
    logic [DATA_W-1:0] status;

    assign wr_ok     = host_wr && !busy;
    assign go        = wr_ok && (host_addr == A_CMD);
    assign status_rd = host_rd && (host_addr == A_CMD);

    tf_param_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_ok (wr_ok),
        .addr  (host_addr),
        .wdata (host_wdata),
        .prm   (prm)
    );

    tf_exec #(.EXEC_CYCLES(EXEC_CYCLES)) u_exec (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .op        (host_wdata),
        .status_rd (status_rd),
        .busy      (busy),
        .drdy      (drdy),
        .err       (err),
        .irq       (irq)
    );

    always_comb begin
        status          = '0;
        status[ST_BUSY] = busy;
        status[ST_RDY]  = drdy;
        status[ST_DRQ]  = 1'b0;
        status[ST_ERR]  = err;
    end

    always_comb begin
        case (host_addr)
            A_COUNT: host_rdata = prm.count;
            A_LBA0:  host_rdata = prm.lba0;
            A_LBA1:  host_rdata = prm.lba1;
            A_LBA2:  host_rdata = prm.lba2;
            A_DEV:   host_rdata = {DEV_MODE_NIB, prm.lba_top};
            A_CMD:   host_rdata = status;
            default: host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tf_taskfile_chk.sv
module tf_taskfile_chk
    import tf_pkg::*;
#(
    parameter int EXEC_CYCLES = 6
)(
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic              host_rd,
    input logic [ADDR_W-1:0] host_addr,
    input logic [DATA_W-1:0] host_wdata,
    input logic              busy,
    input logic              drdy,
    input logic              err,
    input logic              irq,
    input tf_params_t        prm
);

    localparam int RUN_W = $clog2(EXEC_CYCLES + 2);

    logic [RUN_W-1:0] run_q;
    logic cmd_wr;

    assign cmd_wr = host_wr && (host_addr == A_CMD);

    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !drdy);                                             // R4
    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < RUN_W'(EXEC_CYCLES)));                     // R4
    AST_GOOD_START: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy && op_known(host_wdata)) |=> (busy && !err && !irq)); // R4
    AST_BAD_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy && !op_known(host_wdata)) |=> (!busy && err && drdy && irq)); // R5
    AST_PARAMS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(prm));                                      // R6
    AST_NO_START_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cmd_wr) |=> !busy);                               // R8
    AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> irq);                                        // R7
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(host_rd && host_addr == A_CMD) && !(cmd_wr && !busy)) |=> irq); // R7

endmodule

bind disk_taskfile tf_taskfile_chk #(.EXEC_CYCLES(EXEC_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .busy       (busy),
    .drdy       (drdy),
    .err        (err),
    .irq        (irq),
    .prm        (prm)
);

// File: tb/disk_taskfile_test.sv
`timescale 1ns/1ps
module disk_taskfile_test;

    localparam int E = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [2:0] host_addr = 3'd0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    disk_taskfile #(.EXEC_CYCLES(E)) uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .irq(irq)
    );

    // {address, write data, expected read-back}
    localparam logic [18:0] VEC [0:6] = '{
        {3'd0, 8'h12, 8'h12},
        {3'd1, 8'hA5, 8'hA5},
        {3'd2, 8'h3C, 8'h3C},
        {3'd3, 8'hFF, 8'hFF},
        {3'd4, 8'h07, 8'hE7},
        {3'd4, 8'hFA, 8'hEA},
        {3'd0, 8'h00, 8'h00}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] v);
        host_addr = a;
        #1;
        v = host_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd_status(output logic [7:0] v);
        host_rd = 1'b1; host_addr = 3'd5;
        #1;
        v = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(3'd5, v); chk("R1 status", v, 8'h40);
        peek(3'd4, v); chk("R1 device", v, 8'hE0);
        peek(3'd2, v); chk("R1 lba1", v, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);

        // R2/R3 table walk
        for (int i = 0; i < 7; i++) begin
            wr(VEC[i][18:16], VEC[i][15:8]);
            peek(VEC[i][18:16], v);
            chk(VEC[i][18:16] == 3'd4 ? "R3 device nibble" : "R2 readback", v, VEC[i][7:0]);
        end
        // R8: no parameter write started anything
        peek(3'd5, v); chk("R8 idle after params", v, 8'h40);

        // R4 timing of a supported command
        wr(3'd5, 8'h20);
        for (int k = 0; k < E; k++) begin
            peek(3'd5, v); chk("R4 busy window", v, 8'h80);
            @(negedge clk);
        end
        peek(3'd5, v); chk("R4 completion", v, 8'h40);
        chk("R7 irq on done", {7'd0, irq}, 8'h01);
        @(negedge clk);
        chk("R7 irq held", {7'd0, irq}, 8'h01);
        rd_status(v);
        chk("R7 irq cleared by read", {7'd0, irq}, 8'h00);

        // R6 writes during busy ignored, command does not extend
        wr(3'd5, 8'hE7);                     // k=0
        wr(3'd1, 8'h99);                     // k=1
        wr(3'd5, 8'h30);                     // k=2
        for (int k = 2; k < E - 1; k++) @(negedge clk);
        peek(3'd5, v); chk("R6 still busy", v, 8'h80);
        @(negedge clk);
        peek(3'd5, v); chk("R6 no extension", v, 8'h40);
        peek(3'd1, v); chk("R6 param unchanged", v, 8'hA5);
        rd_status(v);

        // R5 unknown opcode
        wr(3'd5, 8'h55);
        peek(3'd5, v); chk("R5 error status", v, 8'h41);
        chk("R5 irq", {7'd0, irq}, 8'h01);
        wr(3'd0, 8'h33);
        peek(3'd0, v); chk("R2 write after error", v, 8'h33);
        peek(3'd5, v); chk("R8 no start, R9 zero bits", v, 8'h41);

        // R7 new good command clears irq and error
        wr(3'd5, 8'h40);
        chk("R7 irq cleared by start", {7'd0, irq}, 8'h00);
        peek(3'd5, v); chk("R4 error cleared", v, 8'h80);
        repeat (E) @(negedge clk);
        peek(3'd5, v); chk("R9 clean completion", v, 8'h40);
        peek(3'd6, v); chk("R9 unused address", v, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule